// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog timer that runs on a slow, always-on clock. Software reaches it through a 32-bit register port with four write targets: a mode word, a timeout length, a reload trigger and a software reset trigger. A write only lands when the data word carries the key value that belongs to that register. Any other write to that register is dropped without effect.

Once enabled, a down-counter runs from the programmed length, counted in units of a fixed number of ticks. Software must reload the counter before it reaches zero. If the counter runs out, the block drives a reset pulse of fixed width. An optional external reset pin mirrors that pulse at a selectable polarity. An expiry also disables the counter and reloads it.

The interrupt, dual and auto-start mode bits are stored and read back. When the interrupt bit or the dual bit is set, an expiry produces no reset pulse. One clock domain is assumed throughout.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the mode register reads 0. The length register reads 0x0000F800, which is a length of 1984 placed at bit 5. The reset output is low. The external pin sits at 1, the idle level for polarity 0.
- R2: A write to offset 0x00 updates the mode only when data bits [31:24] are 0x22. The stored bits are bit 0 (enable), bit 1 (pin polarity, 1 = active high), bit 2 (pin enable), bit 3 (interrupt), bit 4 (auto-start) and bit 6 (dual). A read returns these bits in place, with bit 5 and bits [31:7] as zero.
- R3: A write to offset 0x04 updates the length only when data bits [4:0] are 0x08. The length is taken from bits [15:5]. A read returns the length at bits [15:5], with all other bits zero.
- R4: Let E be the clock edge that takes the write which enables the counter, L the length and T the ticks per unit (512 by default). The reset output rises on edge E+L·T+1. It then stays high for exactly 16 cycles.
- R5: Writing exactly 0x1971 to offset 0x08 reloads the counter to L·T. Any other value written there has no effect on when the counter expires.
- R6: Writing the enable bit as 0 with a valid key freezes the countdown, and no reset follows. Writing it from 0 to 1 restarts the count from the full length.
- R7: An expiry clears mode bit 0 and reloads the counter.
- R8: While mode bit 3 or mode bit 6 is set, an expiry raises no reset pulse. It still clears mode bit 0.
- R9: Writing exactly 0x1209 to offset 0x14 raises the reset output from the next edge for 16 cycles, whether or not the counter is enabled. Any other value written there does nothing.
- R10: While mode bit 2 is set, the external pin equals the reset output if bit 1 is 1, and its inverse if bit 1 is 0. While bit 2 is clear, the pin rests at the inverse of bit 1.
- R11: A valid length write reloads the counter with the new length. The reset then rises on edge W+L·T+1, where W is the edge that takes the length write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow always-on tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data including key bits |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_rst | output | 1 | Active-high system reset pulse |
| ext_rst_pin | output | 1 | External reset pin with selectable polarity |

## Verification
On every cycle, the assertions check several things. Writes with a bad key leave the mode and length registers unchanged. The enabled counter steps down by exactly one. A disabled counter holds its value. The reset pulse counts down without gaps. An expiry with interrupt and dual both off, or a software reset code, raises the reset output on the next edge. An expiry clears the enable bit.

Only the bench scenarios can show the end-to-end timing. This covers the exact edge on which the reset rises for each length in a sweep, the effect of reloads and mid-count length changes, and a frozen count staying frozen. It also covers the external pin level for each polarity and enable setting, and the read-back format of both registers.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_MODE    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_LEN     = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RELOAD  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_SWRESET = 5'h14;

  localparam logic [7:0]  MODE_KEY    = 8'h22;
  localparam logic [4:0]  LEN_KEY     = 5'h08;
  localparam logic [31:0] RELOAD_CODE = 32'h0000_1971;
  localparam logic [31:0] SWRST_CODE  = 32'h0000_1209;

  localparam int MODE_W   = 7;
  localparam int MB_EN    = 0;
  localparam int MB_POL   = 1;
  localparam int MB_PIN   = 2;
  localparam int MB_IRQ   = 3;
  localparam int MB_DUAL  = 6;
  localparam logic [MODE_W-1:0] MODE_MASK = 7'h5F;

  localparam int LEN_LSB = 5;

  // timeout units to clock ticks
  function automatic logic [31:0] units_to_ticks(input logic [31:0] units,
                                                 input logic [31:0] tpu);
    return units * tpu;
  endfunction

  // level driven on the external reset pin
  function automatic logic pin_level(input logic rst, input logic pol,
                                     input logic pin_en);
    if (!pin_en) return ~pol;
    return pol ? rst : ~rst;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1984
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              expire,
  output logic [MODE_W-1:0] mode_q,
  output logic [LEN_W-1:0]  len_d,
  output logic              reload,
  output logic              sw_evt,
  output logic [31:0]       bus_rdata
);
  localparam int PAD_W = 32 - LEN_W - LEN_LSB;

  logic [LEN_W-1:0]  len_q;
  logic [MODE_W-1:0] mode_d;
  logic mode_wr, len_wr, reload_wr, en_rise;

  assign mode_wr   = bus_wr && bus_addr == OFS_MODE && bus_wdata[31:24] == MODE_KEY;
  assign len_wr    = bus_wr && bus_addr == OFS_LEN && bus_wdata[LEN_LSB-1:0] == LEN_KEY;
  assign reload_wr = bus_wr && bus_addr == OFS_RELOAD && bus_wdata == RELOAD_CODE;
  assign sw_evt    = bus_wr && bus_addr == OFS_SWRESET && bus_wdata == SWRST_CODE;

  assign en_rise = mode_wr && bus_wdata[MB_EN] && !mode_q[MB_EN];
  assign reload  = len_wr || reload_wr || en_rise;
  assign len_d   = len_wr ? bus_wdata[LEN_LSB +: LEN_W] : len_q;

  always_comb begin
    mode_d = mode_q;
    if (mode_wr)     mode_d = bus_wdata[MODE_W-1:0] & MODE_MASK;
    else if (expire) mode_d[MB_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      len_q  <= LEN_W'(MAX_LEN);
    end else begin
      mode_q <= mode_d;
      len_q  <= len_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = {{(32-MODE_W){1'b0}}, mode_q};
      OFS_LEN:  bus_rdata = {{PAD_W{1'b0}}, len_q, {LEN_LSB{1'b0}}};
      default:  bus_rdata = '0;
    endcase
  end

  // R2: a mode write with a wrong key leaves the mode alone
  a_r2_mode_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFS_MODE && bus_wdata[31:24] != MODE_KEY && !expire
    |=> $stable(mode_q));
  // R3: a length write with a wrong key leaves the length alone
  a_r3_len_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFS_LEN && bus_wdata[LEN_LSB-1:0] != LEN_KEY
    |=> $stable(len_q));
  // R7: expiry drops the enable bit
  a_r7_expire_disables: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !mode_wr |=> !mode_q[MB_EN]);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int LEN_W          = 11,
  parameter int MAX_LEN        = 1984,
  parameter int TICKS_PER_UNIT = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             reload,
  input  logic [LEN_W-1:0] len_d,
  output logic             expire
);
  localparam int CNT_W = LEN_W + $clog2(TICKS_PER_UNIT);
  localparam logic [CNT_W-1:0] CNT_INIT =
    CNT_W'(units_to_ticks(32'(MAX_LEN), 32'(TICKS_PER_UNIT)));

  logic [CNT_W-1:0] cnt_q, load_val;
  logic             cnt_zero;

  assign load_val = CNT_W'(units_to_ticks(32'(len_d), 32'(TICKS_PER_UNIT)));
  assign cnt_zero = cnt_q == '0;
  assign expire   = en && cnt_zero && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= CNT_INIT;
    else if (reload || expire)  cnt_q <= load_val;
    else if (en && !cnt_zero)   cnt_q <= cnt_q - 1'b1;
  end

  // R4: enabled count steps down by one each tick
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    en && !cnt_zero && !reload |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R6: a disabled count is frozen
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !reload |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
  import wdt_pkg::*;
#(
  parameter int PULSE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pol,
  input  logic pin_en,
  output logic sys_rst,
  output logic ext_rst_pin
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= PW'(PULSE_TICKS);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign sys_rst     = left_q != '0;
  assign ext_rst_pin = pin_level(sys_rst, pol, pin_en);

  // R4: the stretched pulse drains without gaps
  a_r4_pulse_drain: assert property (@(posedge clk) disable iff (!rst_n)
    left_q != '0 && !start |=> left_q == $past(left_q) - PW'(1));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 512,
  parameter int LEN_W          = 11,
  parameter int MAX_LEN        = 1984,
  parameter int PULSE_TICKS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sys_rst,
  output logic        ext_rst_pin
);
  logic [MODE_W-1:0] mode_q;
  logic [LEN_W-1:0]  len_d;
  logic reload, sw_evt, expire, rst_masked, pulse_start;

  wdt_regs #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expire(expire), .mode_q(mode_q), .len_d(len_d),
    .reload(reload), .sw_evt(sw_evt), .bus_rdata(bus_rdata));

  wdt_counter #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN),
                .TICKS_PER_UNIT(TICKS_PER_UNIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(mode_q[MB_EN]), .reload(reload),
    .len_d(len_d), .expire(expire));

  assign rst_masked  = mode_q[MB_IRQ] || mode_q[MB_DUAL];
  assign pulse_start = sw_evt || (expire && !rst_masked);

  wdt_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(pulse_start), .pol(mode_q[MB_POL]),
    .pin_en(mode_q[MB_PIN]), .sys_rst(sys_rst), .ext_rst_pin(ext_rst_pin));

  // R4: an unmasked expiry resets the system on the next edge
  a_r4_expiry_resets: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !rst_masked |=> sys_rst);
  // R9: the software reset code resets on the next edge
  a_r9_swrst_fires: assert property (@(posedge clk) disable iff (!rst_n)
    sw_evt |=> sys_rst);
endmodule

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
  localparam int T = 4;
  localparam int P = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst, ext_rst_pin;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  keyed_wdt #(.TICKS_PER_UNIT(T)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst(sys_rst),
    .ext_rst_pin(ext_rst_pin));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_pin(input logic [31:0] m, input logic r);
    if (m[2] == 1'b0) return !m[1];
    return r == m[1];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    skip(3);
    rst_n = 1'b1;
    skip(1);
    // R1 defaults
    rd(5'h00, v); chk("R1 mode", v, 32'h0);
    rd(5'h04, v); chk("R1 len", v, 32'h0000F800);
    chk("R1 rst", {31'b0, sys_rst}, 32'h0);
    chk("R1 pin", {31'b0, ext_rst_pin}, 32'h1);

    // R2 key gating and field packing
    wr(5'h00, 32'h2300_0001);
    rd(5'h00, v); chk("R2 badkey", v, 32'h0);
    wr(5'h00, 32'h2200_007E);
    rd(5'h00, v); chk("R2 fields", v, 32'h5E);
    wr(5'h00, 32'h2200_0000);
    rd(5'h00, v); chk("R2 clear", v, 32'h0);

    // R3 length key gating
    wr(5'h04, 32'h0000_0149);
    rd(5'h04, v); chk("R3 badkey", v, 32'h0000F800);
    wr(5'h04, 32'h0000_0148);
    rd(5'h04, v); chk("R3 field", v, 32'h140);

    // R4/R7/R10 sweep over lengths and pin settings
    for (int l = 1; l <= 10; l++) begin
      logic [31:0] m;
      m = 32'h2200_0001 | ((l % 2) ? 32'h2 : 32'h0) | ((l % 3) ? 32'h4 : 32'h0);
      wr(5'h04, (32'(l) << 5) | 32'h8);
      wr(5'h00, m);
      skip(l * T);
      chk("R4 before", {31'b0, sys_rst}, 32'h0);
      chk("R10 idle", {31'b0, ext_rst_pin}, {31'b0, exp_pin(m, 1'b0)});
      skip(1);
      chk("R4 rise", {31'b0, sys_rst}, 32'h1);
      chk("R10 active", {31'b0, ext_rst_pin}, {31'b0, exp_pin(m, 1'b1)});
      skip(P - 1);
      chk("R4 width", {31'b0, sys_rst}, 32'h1);
      skip(1);
      chk("R4 end", {31'b0, sys_rst}, 32'h0);
      rd(5'h00, v); chk("R7 en cleared", v, m & 32'h5E);
    end
    wr(5'h00, 32'h2200_0000);

    // R5 wrong reload value has no effect
    wr(5'h04, 32'h0000_0088);
    wr(5'h00, 32'h2200_0001);
    wr(5'h08, 32'h0000_1970);
    skip(14);
    chk("R5 bad before", {31'b0, sys_rst}, 32'h0);
    skip(1);
    chk("R5 bad rise", {31'b0, sys_rst}, 32'h1);
    skip(P);
    // R5 correct reload restarts the count
    wr(5'h00, 32'h2200_0001);
    wr(5'h08, 32'h0000_1972);
    wr(5'h08, 32'h0000_1971);
    skip(13);
    chk("R5 reload held", {31'b0, sys_rst}, 32'h0);
    skip(3);
    chk("R5 reload before", {31'b0, sys_rst}, 32'h0);
    skip(1);
    chk("R5 reload rise", {31'b0, sys_rst}, 32'h1);
    skip(P);

    // R11 length write mid-count
    wr(5'h00, 32'h2200_0001);
    wr(5'h04, 32'h0000_0048);
    skip(8);
    chk("R11 before", {31'b0, sys_rst}, 32'h0);
    skip(1);
    chk("R11 rise", {31'b0, sys_rst}, 32'h1);
    skip(P);

    // R6 stop and restart
    wr(5'h04, 32'h0000_0068);
    wr(5'h00, 32'h2200_0001);
    wr(5'h00, 32'h2200_0000);
    skip(40);
    chk("R6 frozen", {31'b0, sys_rst}, 32'h0);
    wr(5'h00, 32'h2200_0001);
    skip(12);
    chk("R6 full before", {31'b0, sys_rst}, 32'h0);
    skip(1);
    chk("R6 full rise", {31'b0, sys_rst}, 32'h1);
    skip(P);

    // R8 interrupt and dual mask the reset
    wr(5'h04, 32'h0000_0048);
    wr(5'h00, 32'h2200_0009);
    skip(9);
    rd(5'h00, v); chk("R8 irq en cleared", v, 32'h08);
    chk("R8 irq no rst", {31'b0, sys_rst}, 32'h0);
    skip(20);
    chk("R8 irq quiet", {31'b0, sys_rst}, 32'h0);
    wr(5'h00, 32'h2200_0041);
    skip(9);
    rd(5'h00, v); chk("R8 dual en cleared", v, 32'h40);
    chk("R8 dual no rst", {31'b0, sys_rst}, 32'h0);

    // R9 software reset with the counter off, pin active low
    wr(5'h00, 32'h2200_0004);
    wr(5'h14, 32'h0000_1208);
    chk("R9 bad code", {31'b0, sys_rst}, 32'h0);
    wr(5'h14, 32'h0000_1209);
    chk("R9 rise", {31'b0, sys_rst}, 32'h1);
    chk("R10 low pin", {31'b0, ext_rst_pin}, 32'h0);
    skip(P - 1);
    chk("R9 width", {31'b0, sys_rst}, 32'h1);
    skip(1);
    chk("R9 end", {31'b0, sys_rst}, 32'h0);
    chk("R10 low idle", {31'b0, ext_rst_pin}, 32'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule